// File: doc/BRIEF.md
# Calibration Constant Integrity Checker

This block checks a set of calibration constants as they arrive from nonvolatile storage. A byte stream, framed by a start marker and an end marker, is summed modulo 256. In the cycle after the end byte, the running sum is compared with a stored reference byte. A mismatch raises a sticky checksum-error flag, which drives calibration status bit 3.

Separately, four calibration values can be presented together with a one-cycle check strobe:

- a thermocouple offset,
- a high-voltage offset,
- a thermocouple gain,
- a cold-junction sensor offset.

Each value is compared against its own fixed window. If any value falls outside its window, a sticky range-error flag is raised, which drives status bit 2.

The same sequence is used at power-up and again on every calibration pass. Both flags stay set until the controller pulses the clear input.

Top module: `cal_integrity_chk`

## Requirements
- R1: The computed sum is the low 8 bits of the arithmetic sum of every accepted byte, from the most recent start-marked byte through the end-marked byte. A start-marked byte discards any earlier partial sum and begins the new sum with its own value.
- R2: `sum_done_o` is high for exactly one cycle. That cycle is the one immediately after the cycle in which an end-marked byte is accepted.
- R3: During the `sum_done_o` cycle, the computed sum is compared with `stored_sum_i`. A mismatch makes `sum_err_o` read 1 from the next cycle onward. A match leaves `sum_err_o` as it was.
- R4: A cycle with `byte_vld_i` low changes neither the sum nor the markers' effect, whatever `byte_data_i`, `byte_first_i` and `byte_last_i` carry.
- R5: The thermocouple offset is a 16-bit two's-complement value. It is in range when it lies between -365 and +365, both ends included.
- R6: The high-voltage offset is a 16-bit two's-complement value. It is in range when it lies between -583 and +583, both ends included.
- R7: The thermocouple gain is an unsigned 16-bit value with 14 fractional bits. It is in range when it lies between 13107 and 19661, both ends included.
- R8: The cold-junction offset is a 16-bit two's-complement value. It is in range when it lies between -1000 and +1000, both ends included.
- R9: The four values are judged only in a cycle with `range_chk_i` high. If any of them is out of range in that cycle, `range_err_o` reads 1 from the next cycle. Values presented while the strobe is low have no effect.
- R10: Both flags hold at 1 until a cycle with `clr_i` high, after which they read 0. If an error is detected in the same cycle as `clr_i`, that flag reads 1 afterwards.
- R11: After reset, `sum_err_o`, `range_err_o` and `sum_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Clears both sticky error flags |
| byte_vld_i | input | 1 | Byte stream valid |
| byte_first_i | input | 1 | Marks the first byte of a frame |
| byte_last_i | input | 1 | Marks the final byte of a frame |
| byte_data_i | input | 8 | Stream data byte |
| stored_sum_i | input | 8 | Reference checksum byte, sampled in the done cycle |
| range_chk_i | input | 1 | Strobe that judges the four calibration values |
| tc_ofs_i | input | 16 | Thermocouple offset, two's complement |
| hv_ofs_i | input | 16 | High-voltage offset, two's complement |
| tc_gain_i | input | 16 | Thermocouple gain, unsigned, 14 fractional bits |
| cjc_ofs_i | input | 16 | Cold-junction sensor offset, two's complement |
| sum_done_o | output | 1 | One-cycle pulse when the checksum comparison is made |
| sum_err_o | output | 1 | Sticky checksum-error flag (status bit 3) |
| range_err_o | output | 1 | Sticky range-error flag (status bit 2) |

## Verification
The bench builds the block with its default parameters: 8-bit stream bytes, 16-bit calibration values, and the four windows listed above. With 16-bit values, every window edge and the value one step past it can be driven directly, including gain codes above 32767 that would look negative if read as signed. With 8-bit bytes, long frames of high-valued bytes wrap the sum several times. Gaps with the valid input low, and restarted frames, are mixed into the random frames.

// File: rtl/cal_chk_pkg.sv
package cal_chk_pkg;
  localparam int NUM_PARAMS = 4;
  // index order: thermocouple offset, high-voltage offset, gain, cold-junction offset
  localparam int LIM_LO [NUM_PARAMS] = '{-365, -583, 13107, -1000};
  localparam int LIM_HI [NUM_PARAMS] = '{365, 583, 19661, 1000};
  localparam bit LIM_SIGNED [NUM_PARAMS] = '{1'b1, 1'b1, 1'b0, 1'b1};
endpackage

// File: rtl/cal_window_cmp.sv
module cal_window_cmp #(
  parameter int VAL_W     = 16,
  parameter int LO        = 0,
  parameter int HI        = 0,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [VAL_W-1:0] val_i,
  output logic             out_o
);
  localparam int EXT_W = VAL_W + 1;

  logic signed [EXT_W-1:0] val_ext;
  int                      val_int;

  // one extra bit lets signed and unsigned values share a signed compare
  always_comb begin
    if (IS_SIGNED) val_ext = {val_i[VAL_W-1], val_i};
    else           val_ext = {1'b0, val_i};
    val_int = int'(val_ext);
    out_o   = (val_int < LO) || (val_int > HI);
  end
endmodule

// File: rtl/cal_sum_acc.sv
module cal_sum_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] stored_i,
  output logic              done_o,
  output logic              mismatch_o
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              pend_q, pend_d;

  // next state
  always_comb begin
    acc_d  = acc_q;
    pend_d = 1'b0;
    if (vld_i) begin
      acc_d  = first_i ? data_i : DATA_W'(acc_q + data_i);
      pend_d = last_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (vld_i) acc_q <= acc_d;
    end
  end

  assign done_o     = pend_q;
  assign mismatch_o = pend_q && (acc_q != stored_i);

  a_r1_first_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && first_i) |=> (acc_q == $past(data_i)));
  a_r4_idle_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(acc_q));
  a_r2_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && last_i) |=> done_o);
  a_r2_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_i && last_i) |=> !done_o);
endmodule

// File: rtl/cal_integrity_chk.sv
module cal_integrity_chk #(
  parameter int DATA_W = 8,
  parameter int VAL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic              byte_first_i,
  input  logic              byte_last_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic [DATA_W-1:0] stored_sum_i,
  input  logic              range_chk_i,
  input  logic [VAL_W-1:0]  tc_ofs_i,
  input  logic [VAL_W-1:0]  hv_ofs_i,
  input  logic [VAL_W-1:0]  tc_gain_i,
  input  logic [VAL_W-1:0]  cjc_ofs_i,
  output logic              sum_done_o,
  output logic              sum_err_o,
  output logic              range_err_o
);
  import cal_chk_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // checksum path
  logic mismatch;

  cal_sum_acc #(.DATA_W(DATA_W)) u_sum (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .vld_i     (byte_vld_i),
    .first_i   (byte_first_i),
    .last_i    (byte_last_i),
    .data_i    (byte_data_i),
    .stored_i  (stored_sum_i),
    .done_o    (sum_done_o),
    .mismatch_o(mismatch)
  );

  // window path
  logic [VAL_W-1:0]      vals [NUM_PARAMS];
  logic [NUM_PARAMS-1:0] bad;

  always_comb begin
    vals[0] = tc_ofs_i;
    vals[1] = hv_ofs_i;
    vals[2] = tc_gain_i;
    vals[3] = cjc_ofs_i;
  end

  for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_win
    cal_window_cmp #(
      .VAL_W    (VAL_W),
      .LO       (LIM_LO[g]),
      .HI       (LIM_HI[g]),
      .IS_SIGNED(LIM_SIGNED[g])
    ) u_cmp (
      .val_i(vals[g]),
      .out_o(bad[g])
    );
  end

  // sticky flags
  logic sum_err_q, sum_err_d;
  logic range_err_q, range_err_d;

  always_comb begin
    sum_err_d   = (sum_err_q && !clr_i) || mismatch;
    range_err_d = (range_err_q && !clr_i) || (range_chk_i && (|bad));
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sum_err_q   <= 1'b0;
      range_err_q <= 1'b0;
    end else begin
      sum_err_q   <= sum_err_d;
      range_err_q <= range_err_d;
    end
  end

  assign sum_err_o   = sum_err_q;
  assign range_err_o = range_err_q;

  a_r3_mismatch_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    mismatch |=> sum_err_o);
  a_r3_no_done_no_new_err: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sum_done_o && !sum_err_o) |=> !sum_err_o);
  a_r9_no_strobe_no_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!range_chk_i && !range_err_o) |=> !range_err_o);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clr_i && sum_err_o && range_err_o) |=> (sum_err_o && range_err_o));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_i && !sum_done_o && !range_chk_i) |=> (!sum_err_o && !range_err_o));
endmodule

// File: tb/cal_integrity_chk_tb.sv
module cal_integrity_chk_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i, byte_vld_i, byte_first_i, byte_last_i, range_chk_i;
  logic [7:0]  byte_data_i, stored_sum_i;
  logic [15:0] tc_ofs_i, hv_ofs_i, tc_gain_i, cjc_ofs_i;
  logic        sum_done_o, sum_err_o, range_err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cal_integrity_chk u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .byte_vld_i(byte_vld_i), .byte_first_i(byte_first_i), .byte_last_i(byte_last_i),
    .byte_data_i(byte_data_i), .stored_sum_i(stored_sum_i), .range_chk_i(range_chk_i),
    .tc_ofs_i(tc_ofs_i), .hv_ofs_i(hv_ofs_i), .tc_gain_i(tc_gain_i), .cjc_ofs_i(cjc_ofs_i),
    .sum_done_o(sum_done_o), .sum_err_o(sum_err_o), .range_err_o(range_err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit any_bad(input int tc, input int hv, input int g, input int cj);
    return (tc < -365) || (tc > 365) || (hv < -583) || (hv > 583) ||
           (g < 13107) || (g > 19661) || (cj < -1000) || (cj > 1000);
  endfunction

  task automatic pulse_clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  // frame of n bytes; optional idle gaps, aborted prefix, wrong reference, clear in done cycle
  task automatic send_frame(input int n, input bit all_ff, input bit gaps, input bit prefix,
                            input bit corrupt, input bit clr_at_done, input int exp_err);
    byte unsigned bytes [64];
    int sum = 0;
    for (int i = 0; i < n; i++) begin
      bytes[i] = all_ff ? 8'hFF : 8'($urandom);
      sum += bytes[i];
    end
    stored_sum_i = corrupt ? 8'(sum ^ (1 + ($urandom % 255))) : 8'(sum);
    if (prefix) begin
      for (int i = 0; i < 3; i++) begin
        byte_vld_i = 1'b1; byte_first_i = (i == 0); byte_last_i = 1'b0;
        byte_data_i = 8'($urandom);
        @(negedge clk);
      end
    end
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        byte_vld_i = 1'b0; byte_first_i = 1'($urandom); byte_last_i = 1'($urandom);
        byte_data_i = 8'($urandom);
        @(negedge clk);
      end
      byte_vld_i = 1'b1; byte_first_i = (i == 0); byte_last_i = (i == n - 1);
      byte_data_i = bytes[i];
      @(negedge clk);
    end
    byte_vld_i = 1'b0; byte_first_i = 1'b0; byte_last_i = 1'b0;
    check("R2 done pulse after last byte", sum_done_o, 1);
    clr_i = clr_at_done;
    @(negedge clk);
    clr_i = 1'b0;
    check("R2 done lasts one cycle", sum_done_o, 0);
    check("R1/R3/R4 checksum error flag", sum_err_o, exp_err);
  endtask

  task automatic range_case(input string req, input int tc, input int hv, input int g, input int cj);
    pulse_clear();
    check("R10 clear drops range flag", range_err_o, 0);
    tc_ofs_i = 16'(tc); hv_ofs_i = 16'(hv); tc_gain_i = 16'(g); cjc_ofs_i = 16'(cj);
    range_chk_i = 1'b1;
    @(negedge clk);
    range_chk_i = 1'b0;
    check(req, range_err_o, int'(any_bad(tc, hv, g, cj)));
  endtask

  function automatic int pick(input int lo, input int hi, input bit sgn);
    case ($urandom % 6)
      0: return lo - 1;
      1: return lo;
      2: return hi;
      3: return hi + 1;
      4: return lo + int'($urandom % (hi - lo + 1));
      default: return sgn ? int'($signed(16'($urandom))) : int'(16'($urandom));
    endcase
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; clr_i = 1'b0; byte_vld_i = 1'b0; byte_first_i = 1'b0; byte_last_i = 1'b0;
    byte_data_i = '0; stored_sum_i = '0; range_chk_i = 1'b0;
    tc_ofs_i = '0; hv_ofs_i = '0; tc_gain_i = 16'd16384; cjc_ofs_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset sum_err", sum_err_o, 0);
    check("R11 reset range_err", range_err_o, 0);
    check("R11 reset done", sum_done_o, 0);

    // R1 wrap: 20 bytes of 0xFF
    send_frame(20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    // R3 wrong reference
    send_frame(5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1);
    // R10 sticky through a good frame
    send_frame(4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
    pulse_clear();
    check("R10 clear drops sum flag", sum_err_o, 0);
    // R10 set wins over clear in the same cycle
    send_frame(3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1);
    pulse_clear();
    // R1 single-byte frame, and restart after an aborted prefix
    send_frame(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    send_frame(6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

    for (int k = 0; k < 30; k++) begin
      bit c = 1'($urandom);
      pulse_clear();
      send_frame(1 + int'($urandom % 40), 1'b0, 1'b1, 1'($urandom), c, 1'b0, int'(c));
    end

    // window edges
    range_case("R5 tc offset low edge", -365, 0, 16384, 0);
    range_case("R5 tc offset below", -366, 0, 16384, 0);
    range_case("R5 tc offset high edge", 365, 0, 16384, 0);
    range_case("R5 tc offset above", 366, 0, 16384, 0);
    range_case("R6 hv offset low edge", 0, -583, 16384, 0);
    range_case("R6 hv offset below", 0, -584, 16384, 0);
    range_case("R6 hv offset high edge", 0, 583, 16384, 0);
    range_case("R6 hv offset above", 0, 584, 16384, 0);
    range_case("R7 gain low edge", 0, 0, 13107, 0);
    range_case("R7 gain below", 0, 0, 13106, 0);
    range_case("R7 gain high edge", 0, 0, 19661, 0);
    range_case("R7 gain above", 0, 0, 19662, 0);
    range_case("R7 gain top bit set", 0, 0, 40000, 0);
    range_case("R8 cjc offset low edge", 0, 0, 16384, -1000);
    range_case("R8 cjc offset below", 0, 0, 16384, -1001);
    range_case("R8 cjc offset high edge", 0, 0, 16384, 1000);
    range_case("R8 cjc offset above", 0, 0, 16384, 1001);

    // R9: bad values without a strobe are ignored
    pulse_clear();
    tc_ofs_i = 16'(-2000); tc_gain_i = 16'd0;
    repeat (3) @(negedge clk);
    check("R9 no strobe no flag", range_err_o, 0);
    // R10 range flag sticky after values return to range
    range_case("R9 strobe sets flag", 0, 0, 16384, 5000);
    tc_ofs_i = '0; hv_ofs_i = '0; tc_gain_i = 16'd16384; cjc_ofs_i = '0;
    range_chk_i = 1'b1;
    @(negedge clk);
    range_chk_i = 1'b0;
    check("R10 range flag sticky", range_err_o, 1);

    for (int k = 0; k < 60; k++) begin
      range_case("R9 random window mix", pick(-365, 365, 1'b1), pick(-583, 583, 1'b1),
                 pick(13107, 19661, 1'b0), pick(-1000, 1000, 1'b1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule